// File: doc/BRIEF.md
# Serial Transceiver with RTS/CTS Handshaking

This block is a byte-wide asynchronous serial transmitter and receiver with a fixed 8N1 line format: one low start bit, eight data bits with the least significant bit first, and one high stop bit. A baud divisor input sets the rate of an oversampling tick, and one bit lasts sixteen ticks. Bytes to send arrive on a valid/ready interface. Received bytes go into a sixteen-entry first-in first-out buffer. The buffer shows its oldest byte at all times, and a read strobe removes that byte.

A small configuration register turns hardware handshaking on and off. It also holds a software-driven RTS level and a write-one-to-clear action for the sticky overflow flag. With handshaking on, the transmitter starts a new byte only while the synchronized CTS input is high. A byte already on the line always finishes. RTS then drops while the receive buffer holds half its capacity or more. With handshaking off, CTS is ignored and RTS follows the software bit.

Top module: `uart_fc`

## Requirements
- R1: After reset, txd is 1, tx_ready is 1, rts is 0, rx_valid is 0, rx_level is 0 and rx_overflow is 0. Handshaking is off and the software RTS bit is 0.
- R2: A transmitted frame is a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. Each bit lasts 16 ticks, and one tick lasts baud_div clock cycles, where 0 is treated as 1. The line idles at 1.
- R3: A correctly framed byte on rxd is appended to the receive buffer. rx_data shows the oldest stored byte while rx_valid is 1, and a cycle with rx_rd high removes that byte, so bytes come out in arrival order.
- R4: With handshaking off, transmission starts regardless of cts, and rts equals configuration bit 1.
- R5: A configuration write (cfg_wr high) loads bit 5 as the handshaking enable and bit 1 as the software RTS level.
- R6: With handshaking on, a low cts holds tx_ready at 0 and no new frame starts. A frame already started completes unchanged when cts falls during it.
- R7: With handshaking on, rts is 0 while rx_level is 8 or more and 1 while rx_level is below 8, so it rises again once reads bring the level under 8.
- R8: The buffer holds 16 bytes. A byte completed while it is full is discarded, the stored bytes and the level stay unchanged, and rx_overflow is set.
- R9: rx_overflow stays set until a configuration write with bit 7 equal to 1. A write with bit 7 equal to 0 leaves it set.
- R10: A frame whose stop bit is sampled as 0 is not stored. The receiver then waits for the line to return to 1 before it looks for a new start bit.
- R11: cts passes through a two-stage synchronizer, so with handshaking on and the transmitter idle, tx_ready rises on the second rising clock edge after cts rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Clock cycles per oversampling tick |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration data: bit 5 handshake enable, bit 1 software RTS, bit 7 clear overflow |
| tx_valid | input | 1 | Byte to send is valid |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmitter accepts a byte this cycle |
| txd | output | 1 | Serial output line |
| cts | input | 1 | Far end clear to send (high = may send) |
| rxd | input | 1 | Serial input line |
| rts | output | 1 | Request to send to far end (high = may send to this block) |
| rx_valid | output | 1 | Receive buffer not empty |
| rx_data | output | 8 | Oldest received byte |
| rx_rd | input | 1 | Remove the oldest received byte |
| rx_level | output | $clog2(FIFO_DEPTH)+1 | Number of stored bytes |
| rx_overflow | output | 1 | Sticky flag for a byte lost to a full buffer |

## Verification
The transmit path is driven with a fixed pattern (0xA5) and with random bytes at two divisor values. Misordered bits or wrong bit lengths show up as data mismatches at mid-bit sampling points. The receive path gets random bytes, a frame with a low stop bit and a sixteen-plus-one burst. These tell correct storage and ordering apart from framing-error acceptance, from false restarts after an error, and from overwriting a full buffer. Handshaking is exercised by dropping cts partway through a frame, by holding it low across several frame times, and by filling the buffer past its midpoint and draining it. These cases separate boundary-only CTS gating and the half-full RTS threshold from gating that cuts frames or uses the wrong threshold.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int DATA_W      = 8;
  localparam int FRAME_W     = DATA_W + 2;
  localparam int OS_RATE     = 16;
  localparam int OS_MID      = OS_RATE / 2 - 1;
  localparam int CFG_RTS_BIT = 1;
  localparam int CFG_FC_BIT  = 5;
  localparam int CFG_CLR_BIT = 7;

  typedef enum logic [1:0] {RX_IDLE, RX_BUSY, RX_WAIT_HIGH} rx_state_e;

  // Tick counter limit: a divisor of zero behaves as one.
  function automatic int unsigned tick_limit(input int unsigned div);
    return (div == 0) ? 0 : div - 1;
  endfunction

  // Shift word for one 8N1 frame, bit 0 leaves first.
  function automatic logic [FRAME_W-1:0] frame_word(input logic [DATA_W-1:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  // RTS level: buffer room when handshaking, software bit otherwise.
  function automatic logic rts_level(input logic fc_on, input logic sw_bit,
                                     input logic has_room);
    return fc_on ? has_room : sw_bit;
  endfunction
endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= INIT;
        else        stage_q[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= INIT;
        else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              may_start,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic              start_evt
);
  localparam int OSW = $clog2(OS_RATE);
  localparam int BW  = $clog2(FRAME_W);

  logic               busy;
  logic [FRAME_W-1:0] shreg;
  logic [OSW-1:0]     os_cnt;
  logic [BW-1:0]      bit_idx;
  logic               bit_end;

  // CTS is consulted only here, between frames.
  assign in_ready  = !busy && may_start;
  assign start_evt = in_valid && in_ready;
  assign bit_end   = tick && (os_cnt == OSW'(OS_RATE - 1));
  assign txd       = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shreg   <= '1;
      os_cnt  <= '0;
      bit_idx <= '0;
    end else if (start_evt) begin
      busy    <= 1'b1;
      shreg   <= frame_word(in_data);
      os_cnt  <= '0;
      bit_idx <= '0;
    end else if (busy && tick) begin
      os_cnt <= bit_end ? '0 : os_cnt + 1'b1;
      if (bit_end) begin
        if (bit_idx == BW'(FRAME_W - 1)) begin
          busy <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          shreg   <= {1'b1, shreg[FRAME_W-1:1]};
        end
      end
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !txd);  // R2
  AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx == BW'(FRAME_W - 1)) |-> txd);  // R2
  AST_TX_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd));  // R2
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  output logic              push,
  output logic [DATA_W-1:0] push_data
);
  localparam int OSW = $clog2(OS_RATE);
  localparam int BW  = $clog2(FRAME_W);

  rx_state_e         state;
  logic [OSW-1:0]    os_cnt;
  logic [BW-1:0]     bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              mid_bit;

  assign mid_bit = tick && (os_cnt == OSW'(OS_MID));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      os_cnt    <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      push      <= 1'b0;
      push_data <= '0;
    end else begin
      push <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (tick && !rxd_s) begin
            state   <= RX_BUSY;
            os_cnt  <= '0;
            bit_idx <= '0;
          end
        end
        RX_BUSY: begin
          if (tick) os_cnt <= (os_cnt == OSW'(OS_RATE - 1)) ? '0 : os_cnt + 1'b1;
          if (mid_bit) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == '0) begin
              if (rxd_s) state <= RX_IDLE;  // glitch, not a start bit
            end else if (bit_idx <= BW'(DATA_W)) begin
              shreg <= {rxd_s, shreg[DATA_W-1:1]};
            end else if (rxd_s) begin
              push      <= 1'b1;
              push_data <= shreg;
              state     <= RX_IDLE;
            end else begin
              state <= RX_WAIT_HIGH;  // framing error
            end
          end
        end
        RX_WAIT_HIGH: begin
          if (rxd_s) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  AST_RX_STOP_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $past(rxd_s));  // R10
  AST_RX_ERR_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_WAIT_HIGH && !rxd_s) |=> (state == RX_WAIT_HIGH));  // R10
endmodule

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty,
  input  logic                       ovf_clr,
  output logic                       ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk)
    if (do_push) mem[wptr] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (push && full)  ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));  // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (ovf && count == CW'(DEPTH)));  // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);  // R9
endmodule

// File: rtl/uart_fc.sv
module uart_fc
  import uart_fc_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DIV_W-1:0]              baud_div,
  input  logic                          cfg_wr,
  input  logic [7:0]                    cfg_wdata,
  input  logic                          tx_valid,
  input  logic [DATA_W-1:0]             tx_data,
  output logic                          tx_ready,
  output logic                          txd,
  input  logic                          cts,
  input  logic                          rxd,
  output logic                          rts,
  output logic                          rx_valid,
  output logic [DATA_W-1:0]             rx_data,
  input  logic                          rx_rd,
  output logic [$clog2(FIFO_DEPTH):0]   rx_level,
  output logic                          rx_overflow
);
  localparam int CW   = $clog2(FIFO_DEPTH) + 1;
  localparam int HALF = FIFO_DEPTH / 2;

  logic              fc_en, rts_sw, ovf_clr;
  logic [DIV_W-1:0]  div_cnt, div_lim;
  logic              tick;
  logic              cts_s, rxd_s;
  logic              tx_start;
  logic              rx_push;
  logic [DATA_W-1:0] rx_push_data;
  logic              fifo_full, fifo_empty;
  logic              unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata[6], cfg_wdata[4:2], cfg_wdata[0]};

  // Configuration register; the clear bit is an action, not stored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_en  <= 1'b0;
      rts_sw <= 1'b0;
    end else if (cfg_wr) begin
      fc_en  <= cfg_wdata[CFG_FC_BIT];
      rts_sw <= cfg_wdata[CFG_RTS_BIT];
    end
  end
  assign ovf_clr = cfg_wr && cfg_wdata[CFG_CLR_BIT];

  // Free-running oversampling tick shared by both directions.
  assign div_lim = DIV_W'(tick_limit(32'(baud_div)));
  assign tick    = (div_cnt >= div_lim);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 1'b1;

  uart_fc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .d(cts), .q(cts_s));
  uart_fc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

  uart_fc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .may_start(!fc_en || cts_s),
    .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready),
    .txd(txd), .start_evt(tx_start));

  uart_fc_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rxd_s),
    .push(rx_push), .push_data(rx_push_data));

  uart_fc_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(rx_push_data),
    .pop(rx_rd), .rdata(rx_data),
    .count(rx_level), .full(fifo_full), .empty(fifo_empty),
    .ovf_clr(ovf_clr), .ovf(rx_overflow));

  assign rx_valid = !fifo_empty;
  assign rts      = rts_level(fc_en, rts_sw, rx_level < CW'(HALF));

  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && !cts_s) |-> !tx_start);  // R6
  AST_RTS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && fifo_full) |-> !rts);  // R7
  AST_CTS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_en && tx_valid && tx_ready) |=> !txd);  // R4
endmodule

// File: tb/uart_fc_tb.sv
`timescale 1ns/1ps
module uart_fc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] baud_div = 16'd2;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, txd, rts, rx_valid, rx_overflow;
  logic       cts = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_rd = 1'b0;
  logic [4:0] rx_level;

  int n_chk = 0;
  int n_bad = 0;
  bit fc_m = 0;
  bit sw_m = 0;
  byte unsigned q[$];

  always #4 clk = ~clk;

  uart_fc u_dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd),
    .cts(cts), .rxd(rxd), .rts(rts),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_rd(rx_rd),
    .rx_level(rx_level), .rx_overflow(rx_overflow));

  function automatic bit exp_rts(bit fc, bit sw, int lvl);
    return fc ? (lvl < 8) : sw;
  endfunction

  function automatic bit exp_line(byte unsigned b, int idx);
    if (idx == 0) return 1'b0;
    if (idx == 9) return 1'b1;
    return b[idx-1];
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic cfg_write(byte unsigned v);
    cfg_wdata = v; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    fc_m = v[5]; sw_m = v[1];
  endtask

  task automatic tx_put(byte unsigned d);
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic cap_tx(string tag, byte unsigned d);
    int guard = 0;
    while (txd !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (8 * baud_div) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      chk(tag, int'(txd), int'(exp_line(d, i)));
      if (i < 9) repeat (16 * baud_div) @(negedge clk);
    end
  endtask

  task automatic send_rx(byte unsigned b, bit stop_ok);
    for (int i = 0; i < 10; i++) begin
      rxd = (i == 9) ? stop_ok : exp_line(b, i);
      repeat (16 * baud_div) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (16 * baud_div) @(negedge clk);
  endtask

  task automatic model_push(byte unsigned b);
    if (q.size() < 16) q.push_back(b);
  endtask

  task automatic rx_pop(string tag);
    byte unsigned e;
    e = q.pop_front();
    chk(tag, int'(rx_data), int'(e));
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    int lows;
    byte unsigned b;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    chk("R1 txd", int'(txd), 1);
    chk("R1 tx_ready", int'(tx_ready), 1);
    chk("R1 rts", int'(rts), 0);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 rx_level", int'(rx_level), 0);
    chk("R1 rx_overflow", int'(rx_overflow), 0);

    // R4/R5: handshaking off, software RTS bit drives rts, cts ignored
    cfg_write(8'h02);
    chk("R4 rts follows sw bit", int'(rts), int'(exp_rts(fc_m, sw_m, 0)));
    chk("R4 tx_ready with cts low", int'(tx_ready), 1);
    tx_put(8'hA5);
    cap_tx("R2 R4 frame 0xA5", 8'hA5);

    // R2: random bytes at another divisor
    baud_div = 16'd3;
    repeat (60) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      b = byte'($urandom);
      tx_put(b);
      cap_tx("R2 random frame", b);
    end
    repeat (60) @(negedge clk);
    baud_div = 16'd2;
    repeat (20) @(negedge clk);

    // R3: random receive and ordered drain
    for (int k = 0; k < 6; k++) begin
      b = byte'($urandom);
      send_rx(b, 1'b1);
      model_push(b);
      chk("R3 level", int'(rx_level), q.size());
    end
    chk("R3 rx_valid", int'(rx_valid), 1);
    while (q.size() > 0) rx_pop("R3 order");
    chk("R3 empty", int'(rx_valid), 0);

    // R10: bad stop bit dropped, receiver recovers
    send_rx(8'h3C, 1'b0);
    repeat (40) @(negedge clk);
    chk("R10 bad stop not stored", int'(rx_level), 0);
    send_rx(8'hC3, 1'b1);
    model_push(8'hC3);
    chk("R10 next frame stored", int'(rx_level), 1);
    rx_pop("R10 next frame data");

    // R5/R11: enable handshaking, synchronizer latency
    cts = 1'b0;
    cfg_write(8'h20);
    @(negedge clk);
    chk("R5 rts room with sw bit 0", int'(rts), int'(exp_rts(fc_m, sw_m, 0)));
    chk("R5 tx_ready gated by cts", int'(tx_ready), 0);
    cts = 1'b1;
    @(negedge clk);
    chk("R11 one edge", int'(tx_ready), 0);
    @(negedge clk);
    chk("R11 two edges", int'(tx_ready), 1);

    // R6: cts drop mid-frame lets the frame finish, blocks the next
    tx_put(8'h96);
    fork
      cap_tx("R6 frame completes", 8'h96);
      begin repeat (3 * 16 * 2) @(negedge clk); cts = 1'b0; end
    join
    tx_data = 8'h4B; tx_valid = 1'b1;
    lows = 0;
    for (int c = 0; c < 3 * 320; c++) begin
      @(negedge clk);
      if (txd == 1'b0 || tx_ready) lows++;
    end
    chk("R6 no start while cts low", lows, 0);
    cts = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    cap_tx("R6 held byte after cts", 8'h4B);

    // R7/R8/R9: threshold, fill, overflow
    for (int k = 0; k < 8; k++) begin
      b = byte'($urandom);
      send_rx(b, 1'b1);
      model_push(b);
      chk("R7 rts vs level", int'(rts), int'(exp_rts(fc_m, sw_m, q.size())));
    end
    chk("R7 rts low at 8", int'(rts), 0);
    rx_pop("R7 pop data");
    chk("R7 rts back at 7", int'(rts), 1);
    for (int k = 0; k < 10; k++) begin
      b = byte'($urandom);
      send_rx(b, 1'b1);
      model_push(b);
      chk("R7 rts vs level", int'(rts), int'(exp_rts(fc_m, sw_m, q.size())));
    end
    chk("R8 level full", int'(rx_level), 16);
    chk("R8 overflow set", int'(rx_overflow), 1);
    cfg_write(8'h20);
    chk("R9 write without clear", int'(rx_overflow), 1);
    cfg_write(8'hA0);
    chk("R9 clear", int'(rx_overflow), 0);
    while (q.size() > 0) rx_pop("R8 kept bytes");
    chk("R8 drained", int'(rx_level), 0);
    chk("R7 rts after drain", int'(rts), 1);

    summary();
  end
endmodule